// File: doc/BRIEF.md
# Virtual Page Map Unit

This block turns a 32-bit word virtual address into a 32-bit real address. The upper 24 bits of the address are the virtual page number and the low 8 bits are the word offset within a 256-word page. The virtual page number indexes a small direct-indexed map table. Each table entry holds a real page number and three access flags: protected, dirty and referenced. One fixed combination of those flags means the page is not mapped (vacant). A translation either returns the real address or raises a fault. A successful translation records the access in the entry's flags on the same clock edge that it returns its result.

Maintenance software uses three commands on a separate port. Set-entry installs flags and a real page. Get-flags reads an entry. Set-flags reads an entry and, if that entry is mapped, replaces its flags. A command always wins over a translation presented in the same cycle, so every map update is atomic with respect to address translation. Only the low `VPN_IMPL_W` bits of the virtual page number are backed by storage. Any page number above that range behaves as a permanently vacant entry.

Top module: `pageMapUnit`

## Requirements
- R1: A translation accepted in cycle n produces `xlDone` in cycle n+1 with `xlRaddr` = {real page number, `xlVaddr[7:0]`}. The offset passes through unchanged.
- R2: Flag words are 16 bits. Bit 2 is protected, bit 1 is dirty and bit 0 is referenced (LSB-numbered). Bits 15:3 always read as zero, and values written to them are ignored.
- R3: An entry is vacant when its flags equal 3'b110 (word 16'h0006). A read or a write to a vacant page pulses `xlFault` with `xlWpFault`=0, gives no `xlDone`, and leaves the entry unchanged.
- R4: A write to a protected page that is not vacant pulses `xlFault` with `xlWpFault`=1 and leaves the entry unchanged.
- R5: A successful read sets referenced. A successful write sets both referenced and dirty. The next access to the same page sees the updated flags.
- R6: Set-entry (`cmdOp`=1) stores the flags and the real page number. When the new flags are vacant, the supplied real page number is ignored and reads back as zero.
- R7: Get-flags (`cmdOp`=0) returns the entry's flags and real page number one cycle later on `cmdDone`, and changes nothing. The real page number reads as zero for a vacant entry.
- R8: Set-flags (`cmdOp`=2) returns the old flags and real page number. It writes the new flags only if the old entry is not vacant, and it keeps the real page number.
- R9: While `cmdValid` is high, no translation is served. A request held in that cycle gives neither `xlDone` nor `xlFault` and leaves the map untouched.
- R10: A virtual page number at or above 2^`VPN_IMPL_W` reads as vacant. Writes to such a page number are ignored, and translating it raises a page fault.
- R11: After reset every entry is vacant and every output is zero.
- R12: `cmdOp`=3 is reserved. It gives no `cmdDone` and changes no entry.
- R13: The data outputs are zero in any cycle where their strobe (`xlDone` or `cmdDone`) is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xlReq | input | 1 | Translation request |
| xlWrite | input | 1 | 1 = store access, 0 = fetch access |
| xlVaddr | input | 32 | Virtual word address |
| cmdValid | input | 1 | Maintenance command present |
| cmdOp | input | 2 | 0 get-flags, 1 set-entry, 2 set-flags, 3 reserved |
| cmdVpn | input | 24 | Virtual page number for the command |
| cmdFlags | input | 16 | New flag word |
| cmdRpn | input | 24 | New real page number |
| xlDone | output | 1 | Translation succeeded (one-cycle pulse) |
| xlFault | output | 1 | Translation faulted (one-cycle pulse) |
| xlWpFault | output | 1 | With xlFault: 1 write-protect, 0 page fault |
| xlRaddr | output | 32 | Real address |
| cmdDone | output | 1 | Command finished (one-cycle pulse) |
| cmdFlagsOut | output | 16 | Flags of the entry before the command |
| cmdRpnOut | output | 24 | Real page number of the entry before the command |

## Verification
A wrong flag in a table entry does not show at the ports until that page is touched again. It can then appear as a missing or spurious fault on the next translation, or as the wrong flag word on the next get-flags, one cycle after the request. For that reason the bench reads entries back often and interleaves commands with translations to the same few pages. A lost write-back then shows within a few cycles. The bench also holds requests during command cycles, so any leak past command priority appears as an unexpected strobe on the following edge.

// File: rtl/pmuPkg.sv
package pmuPkg;
  localparam int FLAG_IMPL = 3;
  localparam int FLAG_PROT = 2;
  localparam int FLAG_DIRTY = 1;
  localparam int FLAG_REF = 0;
  localparam logic [FLAG_IMPL-1:0] VACANT_CODE = 3'b110;

  localparam logic [1:0] CMD_GET = 2'd0;
  localparam logic [1:0] CMD_SET_ENTRY = 2'd1;
  localparam logic [1:0] CMD_SET_FLAGS = 2'd2;

  typedef enum logic [1:0] {
    SRC_XL = 2'd0,
    SRC_SET_ENTRY = 2'd1,
    SRC_SET_FLAGS = 2'd2
  } wrSrcE;

  typedef struct packed {
    logic tableWe;
    wrSrcE wrSrc;
    logic xlOk;
    logic xlPageFault;
    logic xlWpFault;
    logic cmdReport;
  } pmuStrobeT;
endpackage

// File: rtl/pmuCtrl.sv
module pmuCtrl
  import pmuPkg::*;
(
  input  logic xlReq,
  input  logic xlWrite,
  input  logic cmdValid,
  input  logic [1:0] cmdOp,
  input  logic entVacant,
  input  logic entProt,
  input  logic idxInRange,
  output pmuStrobeT st
);
  always_comb begin
    st = '0;
    st.wrSrc = SRC_XL;
    if (cmdValid) begin
      unique case (cmdOp)
        CMD_GET: st.cmdReport = 1'b1;
        CMD_SET_ENTRY: begin
          st.cmdReport = 1'b1;
          st.tableWe = idxInRange;
          st.wrSrc = SRC_SET_ENTRY;
        end
        CMD_SET_FLAGS: begin
          st.cmdReport = 1'b1;
          st.tableWe = idxInRange & ~entVacant;
          st.wrSrc = SRC_SET_FLAGS;
        end
        default: st.cmdReport = 1'b0;
      endcase
    end else if (xlReq) begin
      if (entVacant) begin
        st.xlPageFault = 1'b1;
      end else if (xlWrite && entProt) begin
        st.xlWpFault = 1'b1;
      end else begin
        st.xlOk = 1'b1;
        st.tableWe = 1'b1;
        st.wrSrc = SRC_XL;
      end
    end
  end
endmodule

// File: rtl/pmuData.sv
module pmuData
  import pmuPkg::*;
#(
  parameter int VA_W = 32,
  parameter int OFF_W = 8,
  parameter int VPN_IMPL_W = 6,
  parameter int FLAG_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  pmuStrobeT st,
  input  logic cmdValid,
  input  logic xlWrite,
  input  logic [VA_W-1:0] xlVaddr,
  input  logic [VA_W-OFF_W-1:0] cmdVpn,
  input  logic [FLAG_W-1:0] cmdFlags,
  input  logic [VA_W-OFF_W-1:0] cmdRpn,
  output logic entVacant,
  output logic entProt,
  output logic idxInRange,
  output logic xlDone,
  output logic xlFault,
  output logic xlWpFault,
  output logic [VA_W-1:0] xlRaddr,
  output logic cmdDone,
  output logic [FLAG_W-1:0] cmdFlagsOut,
  output logic [VA_W-OFF_W-1:0] cmdRpnOut
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int RPN_W = VPN_W;
  localparam int DEPTH = 1 << VPN_IMPL_W;

  logic [FLAG_IMPL-1:0] entFlg [DEPTH];
  logic [RPN_W-1:0] entRpn [DEPTH];

  logic [VPN_W-1:0] selVpn;
  logic [VPN_IMPL_W-1:0] idxLow;
  logic [FLAG_IMPL-1:0] rdFlags;
  logic [RPN_W-1:0] rdRpn;
  logic [FLAG_IMPL-1:0] wFlg;
  logic [RPN_W-1:0] wRpn;
  logic [FLAG_IMPL-1:0] newFlg;

  assign selVpn = cmdValid ? cmdVpn : xlVaddr[VA_W-1:OFF_W];
  assign idxLow = selVpn[VPN_IMPL_W-1:0];
  assign idxInRange = (selVpn[VPN_W-1:VPN_IMPL_W] == '0);
  assign rdFlags = idxInRange ? entFlg[idxLow] : VACANT_CODE;
  assign entVacant = (rdFlags == VACANT_CODE);
  assign entProt = rdFlags[FLAG_PROT];
  assign rdRpn = entVacant ? '0 : entRpn[idxLow];
  assign newFlg = cmdFlags[FLAG_IMPL-1:0];

  always_comb begin
    wFlg = rdFlags;
    wRpn = entRpn[idxLow];
    unique case (st.wrSrc)
      SRC_XL: begin
        wFlg[FLAG_REF] = 1'b1;
        if (xlWrite) wFlg[FLAG_DIRTY] = 1'b1;
      end
      SRC_SET_ENTRY: begin
        wFlg = newFlg;
        wRpn = (newFlg == VACANT_CODE) ? '0 : cmdRpn;
      end
      SRC_SET_FLAGS: wFlg = newFlg;
      default: wFlg = rdFlags;
    endcase
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    logic [FLAG_IMPL-1:0] flgQ;
    logic [RPN_W-1:0] rpnQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flgQ <= VACANT_CODE;
        rpnQ <= '0;
      end else if (st.tableWe && idxLow == VPN_IMPL_W'(gi)) begin
        flgQ <= wFlg;
        rpnQ <= wRpn;
      end
    end
    assign entFlg[gi] = flgQ;
    assign entRpn[gi] = rpnQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xlDone <= 1'b0;
      xlFault <= 1'b0;
      xlWpFault <= 1'b0;
      xlRaddr <= '0;
      cmdDone <= 1'b0;
      cmdFlagsOut <= '0;
      cmdRpnOut <= '0;
    end else begin
      xlDone <= st.xlOk;
      xlFault <= st.xlPageFault | st.xlWpFault;
      xlWpFault <= st.xlWpFault;
      xlRaddr <= st.xlOk ? {rdRpn, xlVaddr[OFF_W-1:0]} : '0;
      cmdDone <= st.cmdReport;
      cmdFlagsOut <= st.cmdReport ? {{(FLAG_W-FLAG_IMPL){1'b0}}, rdFlags} : '0;
      cmdRpnOut <= st.cmdReport ? rdRpn : '0;
    end
  end
endmodule

// File: rtl/pageMapUnit.sv
module pageMapUnit
  import pmuPkg::*;
#(
  parameter int VA_W = 32,
  parameter int OFF_W = 8,
  parameter int VPN_IMPL_W = 6,
  parameter int FLAG_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic xlReq,
  input  logic xlWrite,
  input  logic [VA_W-1:0] xlVaddr,
  input  logic cmdValid,
  input  logic [1:0] cmdOp,
  input  logic [VA_W-OFF_W-1:0] cmdVpn,
  input  logic [FLAG_W-1:0] cmdFlags,
  input  logic [VA_W-OFF_W-1:0] cmdRpn,
  output logic xlDone,
  output logic xlFault,
  output logic xlWpFault,
  output logic [VA_W-1:0] xlRaddr,
  output logic cmdDone,
  output logic [FLAG_W-1:0] cmdFlagsOut,
  output logic [VA_W-OFF_W-1:0] cmdRpnOut
);
  pmuStrobeT st;
  logic entVacant;
  logic entProt;
  logic idxInRange;

  pmuCtrl u_ctrl (
    .xlReq(xlReq),
    .xlWrite(xlWrite),
    .cmdValid(cmdValid),
    .cmdOp(cmdOp),
    .entVacant(entVacant),
    .entProt(entProt),
    .idxInRange(idxInRange),
    .st(st)
  );

  pmuData #(
    .VA_W(VA_W),
    .OFF_W(OFF_W),
    .VPN_IMPL_W(VPN_IMPL_W),
    .FLAG_W(FLAG_W)
  ) u_data (
    .clk(clk),
    .rstN(rstN),
    .st(st),
    .cmdValid(cmdValid),
    .xlWrite(xlWrite),
    .xlVaddr(xlVaddr),
    .cmdVpn(cmdVpn),
    .cmdFlags(cmdFlags),
    .cmdRpn(cmdRpn),
    .entVacant(entVacant),
    .entProt(entProt),
    .idxInRange(idxInRange),
    .xlDone(xlDone),
    .xlFault(xlFault),
    .xlWpFault(xlWpFault),
    .xlRaddr(xlRaddr),
    .cmdDone(cmdDone),
    .cmdFlagsOut(cmdFlagsOut),
    .cmdRpnOut(cmdRpnOut)
  );
endmodule

// File: rtl/pageMapUnitChk.sv
module pageMapUnitChk #(
  parameter int VA_W = 32,
  parameter int OFF_W = 8,
  parameter int VPN_IMPL_W = 6,
  parameter int FLAG_W = 16
) (
  input logic clk,
  input logic rstN,
  input logic xlReq,
  input logic xlWrite,
  input logic [VA_W-1:0] xlVaddr,
  input logic cmdValid,
  input logic [1:0] cmdOp,
  input logic [VA_W-OFF_W-1:0] cmdVpn,
  input logic [FLAG_W-1:0] cmdFlags,
  input logic [VA_W-OFF_W-1:0] cmdRpn,
  input logic xlDone,
  input logic xlFault,
  input logic xlWpFault,
  input logic [VA_W-1:0] xlRaddr,
  input logic cmdDone,
  input logic [FLAG_W-1:0] cmdFlagsOut,
  input logic [VA_W-OFF_W-1:0] cmdRpnOut
);
  // R1: accepted request answers on the next edge with exactly one strobe
  p_one_cycle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (xlReq && !cmdValid) |=> (xlDone ^ xlFault));

  // R1: in-page offset passes through
  p_offset_r1: assert property (@(posedge clk) disable iff (!rstN)
    (xlReq && !cmdValid) |=> (!xlDone || xlRaddr[OFF_W-1:0] == $past(xlVaddr[OFF_W-1:0])));

  // R2: reserved flag bits read as zero
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |-> (cmdFlagsOut[FLAG_W-1:3] == '0));

  // R7: vacant entries report real page zero
  p_vacant_rpn_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDone && cmdFlagsOut[2:0] == 3'b110) |-> (cmdRpnOut == '0));

  // R9: a command cycle serves no translation
  p_cmd_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (!xlDone && !xlFault));

  // R10: page numbers beyond the table fault as vacant
  p_out_of_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    (xlReq && !cmdValid && xlVaddr[VA_W-1:OFF_W+VPN_IMPL_W] != '0) |=> (xlFault && !xlWpFault));

  // R12: reserved op gives no completion
  p_reserved_op_r12: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd3) |=> !cmdDone);

  // R13: data outputs idle low without their strobe
  p_idle_zero_r13: assert property (@(posedge clk) disable iff (!rstN)
    (!xlDone |-> xlRaddr == '0) and (!cmdDone |-> (cmdFlagsOut == '0 && cmdRpnOut == '0)));

  // R3: fault kind only qualifies a fault
  p_wp_qualified_r3: assert property (@(posedge clk) disable iff (!rstN)
    xlWpFault |-> xlFault);
endmodule

bind pageMapUnit pageMapUnitChk #(
  .VA_W(VA_W),
  .OFF_W(OFF_W),
  .VPN_IMPL_W(VPN_IMPL_W),
  .FLAG_W(FLAG_W)
) u_chk (.*);

// File: tb/tb_pageMapUnit.sv
module tb_pageMapUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xlReq = 1'b0;
  logic xlWrite = 1'b0;
  logic [31:0] xlVaddr = '0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [23:0] cmdVpn = '0;
  logic [15:0] cmdFlags = '0;
  logic [23:0] cmdRpn = '0;
  logic xlDone, xlFault, xlWpFault, cmdDone;
  logic [31:0] xlRaddr;
  logic [15:0] cmdFlagsOut;
  logic [23:0] cmdRpnOut;

  pageMapUnit dut (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural model: mapped pages held in associative arrays
  logic [2:0] mFlg [int];
  logic [23:0] mRpn [int];

  logic eXlDone, eXlFault, eXlWp, eCmdDone;
  logic [31:0] eXlRaddr;
  logic [15:0] eCmdFlags;
  logic [23:0] eCmdRpn;
  string prevTag = "R11";

  function automatic logic [2:0] getFlg(int v);
    if (v >= 64) return 3'b110;
    if (!mFlg.exists(v)) return 3'b110;
    return mFlg[v];
  endfunction

  function automatic logic [23:0] getRpn(int v);
    if (getFlg(v) == 3'b110) return '0;
    return mRpn[v];
  endfunction

  task automatic compareOut();
    checks++;
    if ({xlDone, xlFault, xlWpFault, xlRaddr, cmdDone, cmdFlagsOut, cmdRpnOut} !==
        {eXlDone, eXlFault, eXlWp, eXlRaddr, eCmdDone, eCmdFlags, eCmdRpn}) begin
      errors++;
      $display("FAIL %s actual done=%b flt=%b wp=%b ra=%h cd=%b cf=%h cr=%h expected done=%b flt=%b wp=%b ra=%h cd=%b cf=%h cr=%h",
        prevTag, xlDone, xlFault, xlWpFault, xlRaddr, cmdDone, cmdFlagsOut, cmdRpnOut,
        eXlDone, eXlFault, eXlWp, eXlRaddr, eCmdDone, eCmdFlags, eCmdRpn);
    end
  endtask

  task automatic step(input string tag, input logic xr, input logic xw, input logic [31:0] va,
                      input logic cv, input logic [1:0] op, input logic [23:0] vpn,
                      input logic [15:0] fl, input logic [23:0] rpn);
    int v;
    logic [2:0] f;
    @(negedge clk);
    compareOut();
    xlReq = xr; xlWrite = xw; xlVaddr = va;
    cmdValid = cv; cmdOp = op; cmdVpn = vpn; cmdFlags = fl; cmdRpn = rpn;
    eXlDone = 0; eXlFault = 0; eXlWp = 0; eXlRaddr = '0;
    eCmdDone = 0; eCmdFlags = '0; eCmdRpn = '0;
    if (cv) begin
      v = int'(vpn);
      if (op != 2'd3) begin
        f = getFlg(v);
        eCmdDone = 1;
        eCmdFlags = {13'b0, f};
        eCmdRpn = getRpn(v);
        if (v < 64) begin
          if (op == 2'd1) begin
            mFlg[v] = fl[2:0];
            mRpn[v] = (fl[2:0] == 3'b110) ? 24'h0 : rpn;
          end else if (op == 2'd2 && f != 3'b110) begin
            if (!mRpn.exists(v)) mRpn[v] = '0;
            mFlg[v] = fl[2:0];
          end
        end
      end
    end else if (xr) begin
      v = int'(va[31:8]);
      f = getFlg(v);
      if (f == 3'b110) eXlFault = 1;
      else if (xw && f[2]) begin eXlFault = 1; eXlWp = 1; end
      else begin
        eXlDone = 1;
        eXlRaddr = {getRpn(v), va[7:0]};
        mFlg[v] = f | 3'b001 | (xw ? 3'b010 : 3'b000);
      end
    end
    prevTag = tag;
  endtask

  task automatic rd(string t, logic [31:0] a);  step(t, 1, 0, a, 0, 0, 0, 0, 0); endtask
  task automatic wr(string t, logic [31:0] a);  step(t, 1, 1, a, 0, 0, 0, 0, 0); endtask
  task automatic getF(string t, logic [23:0] p); step(t, 0, 0, 0, 1, 2'd0, p, 0, 0); endtask
  task automatic setE(string t, logic [23:0] p, logic [15:0] f, logic [23:0] r);
    step(t, 0, 0, 0, 1, 2'd1, p, f, r);
  endtask
  task automatic setF(string t, logic [23:0] p, logic [15:0] f); step(t, 0, 0, 0, 1, 2'd2, p, f, 0); endtask
  task automatic idle(string t); step(t, 0, 0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    eXlDone = 0; eXlFault = 0; eXlWp = 0; eXlRaddr = '0;
    eCmdDone = 0; eCmdFlags = '0; eCmdRpn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle("R11");
    getF("R11", 24'd5);              // reset leaves entries vacant: 0006 / 0
    rd("R3", 32'h0000_0312);         // vacant read -> page fault
    wr("R3", 32'h0000_0312);         // vacant write -> page fault
    setE("R2", 24'd3, 16'hFFF8, 24'hABCDEF); // reserved bits dropped, flags 0
    getF("R2", 24'd3);
    rd("R1", 32'h0000_0312);         // raddr ABCDEF12
    getF("R5", 24'd3);               // referenced set: 0001
    wr("R5", 32'h0000_03FF);
    getF("R5", 24'd3);               // 0003
    setE("R4", 24'd4, 16'h0004, 24'h123456);
    rd("R4", 32'h0000_0400);
    wr("R4", 32'h0000_0401);         // write-protect fault
    getF("R4", 24'd4);               // 0005, unchanged by fault
    setE("R6", 24'd5, 16'h0006, 24'h777777);
    getF("R6", 24'd5);               // vacant, rpn 0
    setF("R8", 24'd5, 16'h0000);     // no effect on vacant
    getF("R8", 24'd5);
    setF("R8", 24'd3, 16'h0000);     // returns 0003 / ABCDEF
    getF("R8", 24'd3);               // 0000 / ABCDEF
    step("R9", 1, 0, 32'h0000_0300, 1, 2'd0, 24'd3, 0, 0); // collision
    getF("R9", 24'd3);               // still 0000
    step("R12", 1, 0, 32'h0000_0300, 1, 2'd3, 24'd3, 16'h0001, 24'h1); // reserved op
    getF("R12", 24'd3);
    setE("R10", 24'h000100, 16'h0000, 24'h000042);
    getF("R10", 24'h000100);         // vacant
    rd("R10", 32'h0001_0000);        // page fault
    rd("R13", 32'h0000_0310);
    idle("R13");
    for (int i = 0; i < 600; i++) begin
      int sel = $urandom % 8;
      logic [23:0] p = (($urandom % 10) == 0) ? 24'h000040 + 24'($urandom % 4) : 24'($urandom % 8);
      logic [15:0] fl = 16'($urandom);
      if (sel < 4) step("R5", 1, sel[0], {p, 8'($urandom)}, 0, 0, 0, 0, 0);
      else step("R8", sel == 7, 1'b0, {p, 8'h00}, 1, 2'($urandom), p, fl, 24'($urandom));
    end
    idle("R13");
    idle("R13");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule